// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block keeps a small set of recent address translations for a memory system that uses both segments and pages. A logical address arrives as a segment identifier, a page identifier and an in-page offset. The pair of segment and page forms the search key. Every stored entry compares itself against that key in the same cycle. When one entry matches, the block returns a physical address made of the stored physical page number with the offset appended.

When no entry matches, the block does not walk any table itself. It raises a level interrupt and keeps the faulting segment and page in capture registers. Software then walks the segment and page tables in memory, deals with any page fault, and writes the finished translation in through an insert port. That insert also clears the interrupt.

New translations fill empty entries first. Once every entry is in use, a new translation replaces the entry that was inserted longest ago, so the buffer always holds the latest translations. A flush input empties the whole buffer in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: After reset, rs_valid, rs_hit and miss_irq are 0 and no entry is valid, so every lookup misses.
- R2: A lookup presented with lk_valid=1 at a clock edge produces rs_valid=1 in the following cycle. rs_valid is 0 in every cycle that follows an edge with lk_valid=0.
- R3: A lookup hits only when a valid entry matches both the segment and the page. On a hit, rs_hit=1 and rs_paddr={stored ppn, lk_off}, with the page number in the upper PPN_W bits and the offset in the lower OFF_W bits.
- R4: On a miss, rs_hit=0 and rs_paddr=0. In the same following cycle, miss_irq=1.
- R5: miss_irq stays at 1 until an edge where ins_valid or miss_ack is 1. The capture registers hold the segment and page of the first unserviced miss, and later misses do not change them while the interrupt is pending. A miss on the same edge as a clear request loads a new capture and keeps the interrupt asserted.
- R6: An insert takes effect at its clock edge. A lookup at that same edge still sees the old contents, and a lookup at a later edge sees the new entry.
- R7: Inserts with new keys fill entries in insertion order. When every entry is valid, a new key replaces the entry that was inserted earliest.
- R8: Inserting a key that is already stored replaces only that entry's physical page number. No second entry is created, and the entry keeps its place in the replacement order.
- R9: flush invalidates every entry at its clock edge and has priority over an insert on the same edge, which is dropped. Filling then restarts from the first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_seg | input | SEG_W | Logical segment identifier of the lookup |
| lk_page | input | PAGE_W | Logical page identifier of the lookup |
| lk_off | input | OFF_W | Offset within the page |
| rs_valid | output | 1 | Lookup result valid (one cycle after the request) |
| rs_hit | output | 1 | Lookup found a matching entry |
| rs_paddr | output | PPN_W+OFF_W | Physical address on a hit, zero on a miss |
| miss_irq | output | 1 | Miss interrupt request, held until serviced |
| miss_seg | output | SEG_W | Captured segment of the pending miss |
| miss_page | output | PAGE_W | Captured page of the pending miss |
| miss_ack | input | 1 | Software clears the miss without inserting |
| ins_valid | input | 1 | Insert a translation |
| ins_seg | input | SEG_W | Segment of the inserted translation |
| ins_page | input | PAGE_W | Page of the inserted translation |
| ins_ppn | input | PPN_W | Physical page number of the inserted translation |
| flush | input | 1 | Invalidate all entries |

## Verification
Every result is registered once. rs_valid, rs_hit, rs_paddr, miss_irq and the capture registers all reflect the request presented at one edge and appear right after that edge. An insert or flush at edge N changes what a lookup at edge N+1 sees, but not a lookup at edge N. The bench drives each request 2 ns after a rising edge. It computes the expected outputs from a model of the table taken before that edge, and samples them 2 ns after the next rising edge. This makes the same-edge cases of R6, R5 and R9 fall out of one fixed sampling point.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Supported buffer depths.
  function automatic bit depth_ok(input int n);
    return (n == 8) || (n == 16);
  endfunction

  // Index width for a given entry count.
  function automatic int idx_width(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/xlat_entry.sv
module xlat_entry #(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 6,
  parameter int PPN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [SEG_W-1:0]  lk_seg,
  input  logic [PAGE_W-1:0] lk_page,
  input  logic [SEG_W-1:0]  in_seg,
  input  logic [PAGE_W-1:0] in_page,
  output logic              lk_match,
  output logic              in_match,
  output logic [PPN_W-1:0]  ppn
);

  logic              valid_q;
  logic [SEG_W-1:0]  seg_q;
  logic [PAGE_W-1:0] page_q;
  logic [PPN_W-1:0]  ppn_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid_q <= 1'b0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) begin
      seg_q  <= wr_seg;
      page_q <= wr_page;
      ppn_q  <= wr_ppn;
    end
  end

  assign lk_match = valid_q && (seg_q == lk_seg) && (page_q == lk_page);
  assign in_match = valid_q && (seg_q == in_seg) && (page_q == in_page);
  assign ppn      = ppn_q;

  // R9: a flush leaves the entry empty at the next cycle
  a_r9_entry_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> !valid_q);

endmodule

// File: rtl/xlat_select.sv
module xlat_select #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic [N-1:0]        match,
  input  logic [N-1:0][W-1:0] data,
  output logic                hit,
  output logic [W-1:0]        q
);

  always_comb begin
    q = '0;
    for (int i = 0; i < N; i++) begin
      q = q | (data[i] & {W{match[i]}});
    end
  end

  assign hit = |match;

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
    end
  end

  // R9: filling restarts from entry 0 after a flush
  a_r9_ptr_restart: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ptr == '0));

  // R7: the pointer moves by exactly one slot per new-key insert
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !flush) |=> (ptr == (($past(ptr) == IDX_W'(N - 1)) ? '0 : $past(ptr) + 1'b1)));

endmodule

// File: rtl/xlat_miss_ctl.sv
module xlat_miss_ctl #(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss,
  input  logic              clr,
  input  logic [SEG_W-1:0]  seg,
  input  logic [PAGE_W-1:0] page,
  output logic              irq,
  output logic [SEG_W-1:0]  cap_seg,
  output logic [PAGE_W-1:0] cap_page
);

  logic load;
  assign load = miss && (!irq || clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      cap_seg  <= '0;
      cap_page <= '0;
    end else begin
      irq <= (irq && !clr) || miss;
      if (load) begin
        cap_seg  <= seg;
        cap_page <= page;
      end
    end
  end

  // R5: the request is held until software services it
  a_r5_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq);

  // R5: the first unserviced miss keeps its capture
  a_r5_capture_stable: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> ($stable(cap_seg) && $stable(cap_page)));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 8,
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 6,
  parameter int OFF_W   = 10,
  parameter int PPN_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lk_valid,
  input  logic [SEG_W-1:0]       lk_seg,
  input  logic [PAGE_W-1:0]      lk_page,
  input  logic [OFF_W-1:0]       lk_off,
  output logic                   rs_valid,
  output logic                   rs_hit,
  output logic [PPN_W+OFF_W-1:0] rs_paddr,
  output logic                   miss_irq,
  output logic [SEG_W-1:0]       miss_seg,
  output logic [PAGE_W-1:0]      miss_page,
  input  logic                   miss_ack,
  input  logic                   ins_valid,
  input  logic [SEG_W-1:0]       ins_seg,
  input  logic [PAGE_W-1:0]      ins_page,
  input  logic [PPN_W-1:0]       ins_ppn,
  input  logic                   flush
);

  import xlat_pkg::*;

  localparam int IDX_W = idx_width(ENTRIES);
  localparam int PA_W  = PPN_W + OFF_W;

  if (!depth_ok(ENTRIES)) begin : g_depth_check
    $error("xlat_cache: ENTRIES must be 8 or 16");
  end

  logic [ENTRIES-1:0]            lk_match;
  logic [ENTRIES-1:0]            in_match;
  logic [ENTRIES-1:0]            wr_en;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_all;
  logic [IDX_W-1:0]              ptr;
  logic                          key_present;
  logic                          lk_hit;
  logic [PPN_W-1:0]              lk_ppn;
  logic                          ins_take;

  assign key_present = |in_match;
  assign ins_take    = ins_valid && !flush;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign wr_en[i] = ins_take &&
                      (key_present ? in_match[i] : (ptr == IDX_W'(i)));

    xlat_entry #(
      .SEG_W (SEG_W),
      .PAGE_W(PAGE_W),
      .PPN_W (PPN_W)
    ) u_entry (
      .clk     (clk),
      .rst     (rst),
      .clr     (flush),
      .wr_en   (wr_en[i]),
      .wr_seg  (ins_seg),
      .wr_page (ins_page),
      .wr_ppn  (ins_ppn),
      .lk_seg  (lk_seg),
      .lk_page (lk_page),
      .in_seg  (ins_seg),
      .in_page (ins_page),
      .lk_match(lk_match[i]),
      .in_match(in_match[i]),
      .ppn     (ppn_all[i])
    );
  end

  xlat_select #(
    .N(ENTRIES),
    .W(PPN_W)
  ) u_select (
    .match(lk_match),
    .data (ppn_all),
    .hit  (lk_hit),
    .q    (lk_ppn)
  );

  xlat_victim #(
    .N    (ENTRIES),
    .IDX_W(IDX_W)
  ) u_victim (
    .clk  (clk),
    .rst  (rst),
    .flush(flush),
    .adv  (ins_take && !key_present),
    .ptr  (ptr)
  );

  xlat_miss_ctl #(
    .SEG_W (SEG_W),
    .PAGE_W(PAGE_W)
  ) u_miss (
    .clk     (clk),
    .rst     (rst),
    .miss    (lk_valid && !lk_hit),
    .clr     (ins_valid || miss_ack),
    .seg     (lk_seg),
    .page    (lk_page),
    .irq     (miss_irq),
    .cap_seg (miss_seg),
    .cap_page(miss_page)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_paddr <= '0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= lk_valid && lk_hit;
      rs_paddr <= (lk_valid && lk_hit) ? {lk_ppn, lk_off} : PA_W'(0);
    end
  end

  // R8: a key is never stored in two entries
  a_r8_no_duplicate: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R2: result valid follows the request by one cycle
  a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rs_valid);

  // R4: a miss raises the interrupt in the following cycle
  a_r4_miss_raises: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_hit) |=> (miss_irq && !rs_hit));

  // R9: a lookup right after a flush misses
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush ##1 lk_valid |=> (rs_valid && !rs_hit));

endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;

  localparam int N      = 8;
  localparam int SEG_W  = 4;
  localparam int PAGE_W = 6;
  localparam int OFF_W  = 10;
  localparam int PPN_W  = 8;
  localparam int PA_W   = PPN_W + OFF_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              lk_valid;
  logic [SEG_W-1:0]  lk_seg;
  logic [PAGE_W-1:0] lk_page;
  logic [OFF_W-1:0]  lk_off;
  logic              rs_valid, rs_hit;
  logic [PA_W-1:0]   rs_paddr;
  logic              miss_irq;
  logic [SEG_W-1:0]  miss_seg;
  logic [PAGE_W-1:0] miss_page;
  logic              miss_ack, ins_valid, flush;
  logic [SEG_W-1:0]  ins_seg;
  logic [PAGE_W-1:0] ins_page;
  logic [PPN_W-1:0]  ins_ppn;

  int checks = 0;
  int errors = 0;

  // Reference state computed from the requirements
  bit                m_val [N];
  logic [SEG_W-1:0]  m_seg [N];
  logic [PAGE_W-1:0] m_page[N];
  logic [PPN_W-1:0]  m_ppn [N];
  int                m_ptr;
  bit                m_pend;
  logic [SEG_W-1:0]  m_cseg;
  logic [PAGE_W-1:0] m_cpage;

  always #5 clk = ~clk;

  xlat_cache #(
    .ENTRIES(N), .SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .PPN_W(PPN_W)
  ) u_dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_seg(lk_seg), .lk_page(lk_page), .lk_off(lk_off),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_paddr(rs_paddr),
    .miss_irq(miss_irq), .miss_seg(miss_seg), .miss_page(miss_page),
    .miss_ack(miss_ack), .ins_valid(ins_valid), .ins_seg(ins_seg),
    .ins_page(ins_page), .ins_ppn(ins_ppn), .flush(flush)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int find_key(input logic [SEG_W-1:0] s, input logic [PAGE_W-1:0] p);
    for (int i = 0; i < N; i++)
      if (m_val[i] && m_seg[i] == s && m_page[i] == p) return i;
    return -1;
  endfunction

  // One cycle: drive, predict, wait one edge, sample 2 ns later.
  task automatic step(input string tag, input bit lv, input logic [SEG_W-1:0] s,
                      input logic [PAGE_W-1:0] p, input logic [OFF_W-1:0] o,
                      input bit iv, input logic [SEG_W-1:0] is,
                      input logic [PAGE_W-1:0] ip, input logic [PPN_W-1:0] ippn,
                      input bit fl, input bit ak);
    int  h;
    int  k;
    bit  exp_hit;
    logic [PA_W-1:0] exp_pa;
    bit  clr;
    lk_valid = lv; lk_seg = s; lk_page = p; lk_off = o;
    ins_valid = iv; ins_seg = is; ins_page = ip; ins_ppn = ippn;
    flush = fl; miss_ack = ak;
    h = find_key(s, p);
    exp_hit = lv && (h >= 0);
    exp_pa  = exp_hit ? {m_ppn[h], o} : '0;
    clr = iv || ak;
    if (lv && !exp_hit && (!m_pend || clr)) begin
      m_cseg = s; m_cpage = p;
    end
    m_pend = (m_pend && !clr) || (lv && !exp_hit);
    if (fl) begin
      for (int i = 0; i < N; i++) m_val[i] = 1'b0;
      m_ptr = 0;
    end else if (iv) begin
      k = find_key(is, ip);
      if (k >= 0) begin
        m_ppn[k] = ippn;
      end else begin
        m_val[m_ptr] = 1'b1; m_seg[m_ptr] = is; m_page[m_ptr] = ip;
        m_ppn[m_ptr] = ippn;
        m_ptr = (m_ptr + 1) % N;
      end
    end
    @(posedge clk);
    #2;
    chk({tag, " R2 rs_valid"}, 32'(rs_valid), 32'(lv));
    chk({tag, exp_hit ? " R3 rs_hit" : " R4 rs_hit"}, 32'(rs_hit), 32'(exp_hit));
    chk({tag, exp_hit ? " R3 rs_paddr" : " R4 rs_paddr"}, 32'(rs_paddr), 32'(exp_pa));
    chk({tag, " R5 miss_irq"}, 32'(miss_irq), 32'(m_pend));
    if (m_pend) begin
      chk({tag, " R5 miss_seg"}, 32'(miss_seg), 32'(m_cseg));
      chk({tag, " R5 miss_page"}, 32'(miss_page), 32'(m_cpage));
    end
  endtask

  task automatic look(input string tag, input logic [SEG_W-1:0] s, input logic [PAGE_W-1:0] p,
                      input logic [OFF_W-1:0] o);
    step(tag, 1'b1, s, p, o, 1'b0, '0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic put(input string tag, input logic [SEG_W-1:0] s, input logic [PAGE_W-1:0] p,
                     input logic [PPN_W-1:0] q);
    step(tag, 1'b0, '0, '0, '0, 1'b1, s, p, q, 1'b0, 1'b0);
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit lv, iv, fl, ak;
    process::self().srandom(32'd1234);
    rst = 1'b1;
    lk_valid = 0; lk_seg = '0; lk_page = '0; lk_off = '0;
    ins_valid = 0; ins_seg = '0; ins_page = '0; ins_ppn = '0;
    flush = 0; miss_ack = 0;
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    m_ptr = 0; m_pend = 0; m_cseg = '0; m_cpage = '0;
    repeat (4) @(posedge clk);
    #2;
    rst = 1'b0;
    // R1: reset state of the outputs
    chk("R1 rs_valid", 32'(rs_valid), 0);
    chk("R1 rs_hit", 32'(rs_hit), 0);
    chk("R1 miss_irq", 32'(miss_irq), 0);

    // R1/R4: empty buffer misses and raises the interrupt
    look("R1 empty", 4'h3, 6'h11, 10'h2a5);
    // R5: a second miss keeps the first capture
    look("R5 second miss", 4'h5, 6'h22, 10'h001);
    // R5: acknowledge clears the pending request
    step("R5 ack", 0, '0, '0, '0, 0, '0, '0, '0, 0, 1);
    // R6: lookup in the insert cycle still misses, then hits
    step("R6 same edge", 1, 4'h3, 6'h11, 10'h155, 1, 4'h3, 6'h11, 8'h9c, 0, 0);
    look("R6 after insert", 4'h3, 6'h11, 10'h3ff);
    // R3: page differs, segment same -> miss; segment differs -> miss
    look("R3 page differs", 4'h3, 6'h12, 10'h000);
    look("R3 seg differs", 4'h2, 6'h11, 10'h000);
    step("R5 ack2", 0, '0, '0, '0, 0, '0, '0, '0, 0, 1);

    // R7: fill all slots, then one more evicts the oldest
    for (int i = 1; i < N; i++) put("R7 fill", 4'(i), 6'(i + 8), 8'(i * 3));
    look("R7 oldest present", 4'h3, 6'h11, 10'h010);
    put("R7 evict", 4'hf, 6'h3f, 8'hee);
    look("R7 oldest gone", 4'h3, 6'h11, 10'h010);
    look("R7 second kept", 4'h1, 6'h09, 10'h020);
    look("R7 newest", 4'hf, 6'h3f, 10'h030);

    // R8: re-insert an existing key updates in place, keeps its age
    put("R8 dup", 4'h1, 6'h09, 8'h77);
    look("R8 updated ppn", 4'h1, 6'h09, 10'h0aa);
    put("R8 next evict", 4'he, 6'h01, 8'h55);
    look("R8 dup evicted as oldest", 4'h1, 6'h09, 10'h0aa);
    look("R8 neighbour kept", 4'h2, 6'h0a, 10'h0bb);

    // R9: flush beats a same-edge insert, then fill restarts
    step("R9 flush+ins", 0, '0, '0, '0, 1, 4'h7, 6'h07, 8'h01, 1, 0);
    look("R9 flushed", 4'hf, 6'h3f, 10'h001);
    look("R9 dropped insert", 4'h7, 6'h07, 10'h001);
    put("R9 refill", 4'h7, 6'h07, 8'h42);
    look("R9 refill hit", 4'h7, 6'h07, 10'h123);

    // Random phase with a small key space to mix hits and misses
    for (int n = 0; n < 3000; n++) begin
      lv = ($urandom % 2) == 0;
      iv = ($urandom % 4) == 0;
      fl = ($urandom % 64) == 0;
      ak = ($urandom % 8) == 0;
      step("RND", lv, 4'($urandom % 4), 6'($urandom % 8), 10'($urandom),
           iv, 4'($urandom % 4), 6'($urandom % 8), 8'($urandom), fl, ak);
    end
    step("END", 0, '0, '0, '0, 0, '0, '0, '0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule